// File: doc/BRIEF.md
# Power Mode and Clock Source Controller

This block decides, cycle by cycle, whether the processor core and the peripheral domain of a small controller receive a clock, and which of three oscillators drives them. It holds one 8-bit control register. Bit 7 is the idle-enable flag. Bits 1:0 are the source-select field. A one-cycle sleep command moves the block out of Run. The idle flag, as it stands when that command arrives, decides the result. If the flag is 1, only the core clock stops (Idle). If it is 0, every clock stops and no source is driven (Sleep). A wake event brings the block back to Run.

Changing the source-select field asks for an immediate move to another oscillator. The move is only made once that oscillator raises its ready flag. Until then the old source stays selected and the reported mode does not change. The three ready flags and the control pins are plain level signals. There is no data stream, so no valid/ready handshake is used.

The mode status output is a 3-bit code. Bit 2 is set in Idle. Bits 1:0 name the source: 01 primary, 10 secondary, 11 internal. The code 000 means that all clocks are off.

Top module: `pmc_top`

## Requirements
- R1: After reset the register reads as zero, the mode code is 001 (primary Run), both clock enables are 1 and the source output is 01.
- R2: In Run both `cpu_clk_en` and `per_clk_en` are 1, and `mode_code` is {0, active source code}.
- R3: A `sleep_cmd` seen in Run while the idle flag (register bit 7) is 1 gives Idle on the next cycle. In Idle, `cpu_clk_en`=0, `per_clk_en`=1, `clk_sel` keeps the active source and `mode_code` is {1, source code}.
- R4: A `sleep_cmd` seen in Run while the idle flag is 0 gives Sleep on the next cycle. In Sleep both enables are 0, `clk_sel`=00 and `mode_code`=000.
- R5: The idle flag is taken from the register value held before the cycle of the command. A register write in the same cycle as `sleep_cmd` does not affect that command.
- R6: The select field (bits 1:0) decodes as follows: 00 primary, 01 secondary, 10 and 11 internal. The `clk_sel` codes are 01 primary, 10 secondary and 11 internal. `src_ready` bit 0 is primary, bit 1 is secondary and bit 2 is internal.
- R7: In Run or Idle, a selected source that differs from the active one becomes active on the cycle after its ready bit is seen high. While it waits, `clk_sel` and `mode_code` keep the old source.
- R8: A `wake` seen in Idle gives Run on the next cycle.
- R9: A `wake` seen in Sleep gives Run on the next cycle with the selected source, if that source's ready bit is high. Otherwise all clocks stay off, and Run with that source starts on the cycle after its ready bit is first seen high.
- R10: `sleep_cmd` has no effect outside Run, and `wake` has no effect in Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Control register write value (bit 7 idle flag, bits 1:0 source select) |
| sleep_cmd | input | 1 | One-cycle request to leave Run |
| wake | input | 1 | Wake event |
| src_ready | input | 3 | Oscillator running flags: bit 0 primary, bit 1 secondary, bit 2 internal |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clk_sel | output | 2 | Driven source: 00 none, 01 primary, 10 secondary, 11 internal |
| mode_code | output | 3 | Current mode code |

## Verification
The hardest case to reach is a wake from Sleep in which the selected oscillator is not yet running, while a source change requested earlier is still pending. To reach it, the stimulus asks for a source whose ready bit is held low and then enters Sleep with that request still pending. It raises the wake event with the ready bit still low and holds it low for several cycles before releasing it. A reference model in the bench, updated on every edge, gives the expected enables, source and mode code. This makes both the waiting interval and the cycle on which the clocks return checkable.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_PRI  = 2'b01,
    SRC_SEC  = 2'b10,
    SRC_INT  = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } pstate_e;

  // select field to source (R6)
  function automatic src_e decode_sel(input logic [1:0] field);
    case (field)
      2'b00:   return SRC_PRI;
      2'b01:   return SRC_SEC;
      default: return SRC_INT;
    endcase
  endfunction
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg #(
  parameter int REG_W    = 8,
  parameter int IDLE_BIT = 7,
  parameter int SEL_LSB  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic             idle_en,
  output logic [1:0]       sel_field
);
  logic [REG_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (we) ctl_q <= wdata;
  end

  assign idle_en   = ctl_q[IDLE_BIT];
  assign sel_field = ctl_q[SEL_LSB+1:SEL_LSB];

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctl_q));
endmodule

// File: rtl/pmc_src_switch.sv
module pmc_src_switch
  import pmc_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               allow,
  input  src_e               target,
  input  logic [NUM_SRC-1:0] src_ready,
  output logic               tgt_ready,
  output src_e               active
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_match
    assign hit[g] = (target == src_e'(2'(g + 1))) && src_ready[g];
  end

  assign tgt_ready = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= SRC_PRI;
    else if (allow && tgt_ready) active <= target;
  end

  // source only moves after its ready flag was seen (R7)
  assert_switch_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active != $past(active)) |-> ($past(tgt_ready) && $past(allow)));
  assert_never_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active != SRC_NONE);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sleep_cmd,
  input  logic    wake,
  input  logic    idle_en,
  input  logic    tgt_ready,
  output pstate_e state,
  output logic    allow
);
  pstate_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:   if (sleep_cmd) nxt = idle_en ? ST_IDLE : ST_SLEEP;
      ST_IDLE:  if (wake) nxt = ST_RUN;
      ST_SLEEP: if (wake) nxt = tgt_ready ? ST_RUN : ST_WAKE;
      ST_WAKE:  if (tgt_ready) nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  assign allow = (state == ST_RUN) || (state == ST_IDLE) || (state == ST_WAKE) ||
                 ((state == ST_SLEEP) && wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else state <= nxt;
  end

  assert_idle_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && wake) |=> state == ST_RUN);
  assert_leave_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && sleep_cmd) |=> state != ST_RUN);
  assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !wake) |=> state == ST_SLEEP);
  assert_wake_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && !tgt_ready) |=> state == ST_WAKE);
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int IDLE_BIT = 7,
  parameter int SEL_LSB  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             sleep_cmd,
  input  logic             wake,
  input  logic [2:0]       src_ready,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic [1:0]       clk_sel,
  output logic [2:0]       mode_code
);
  localparam int NUM_SRC = 3;

  logic    idle_en, tgt_ready, allow;
  logic [1:0] sel_field;
  src_e    target, active;
  pstate_e state;

  pmc_ctrl_reg #(.REG_W(REG_W), .IDLE_BIT(IDLE_BIT), .SEL_LSB(SEL_LSB)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .idle_en(idle_en), .sel_field(sel_field));

  assign target = decode_sel(sel_field);

  pmc_src_switch #(.NUM_SRC(NUM_SRC)) u_sw (
    .clk(clk), .rst_n(rst_n), .allow(allow), .target(target),
    .src_ready(src_ready), .tgt_ready(tgt_ready), .active(active));

  pmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .wake(wake),
    .idle_en(idle_en), .tgt_ready(tgt_ready), .state(state), .allow(allow));

  logic clocked;
  assign clocked    = (state == ST_RUN) || (state == ST_IDLE);
  assign cpu_clk_en = (state == ST_RUN);
  assign per_clk_en = clocked;
  assign clk_sel    = clocked ? active : SRC_NONE;
  assign mode_code  = clocked ? {state == ST_IDLE, active} : 3'b000;

  assert_cpu_needs_per_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> per_clk_en);
  assert_sleep_no_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !per_clk_en |-> (clk_sel == 2'b00 && mode_code == 3'b000));
  assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_clk_en && !cpu_clk_en) |-> mode_code[2]);
endmodule

// File: tb/sim_pmc_top.sv
module sim_pmc_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic sleep_cmd = 1'b0;
  logic wake = 1'b0;
  logic [2:0] src_ready = 3'b111;
  logic cpu_clk_en, per_clk_en;
  logic [1:0] clk_sel;
  logic [2:0] mode_code;

  always #2 clk = ~clk;

  pmc_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .sleep_cmd(sleep_cmd), .wake(wake), .src_ready(src_ready),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .clk_sel(clk_sel), .mode_code(mode_code));

  // reference model: ms 0 run, 1 idle, 2 sleep, 3 waiting for oscillator
  int ms, ma, mi, mf;
  int total = 0, fails = 0;
  bit done = 0;
  string last_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; ma = 1; mi = 0; mf = 0;
    end else begin
      int tgt, ns;
      bit r, allow;
      tgt = (mf == 0) ? 1 : (mf == 1) ? 2 : 3;
      r = src_ready[tgt-1];
      allow = (ms == 0) || (ms == 1) || (ms == 3) || (ms == 2 && wake);
      ns = ms;
      case (ms)
        0: if (sleep_cmd) ns = mi ? 1 : 2;
        1: if (wake) ns = 0;
        2: if (wake) ns = r ? 0 : 3;
        default: if (r) ns = 0;
      endcase
      if (allow && r) ma = tgt;
      if (reg_we) begin mi = reg_wdata[7]; mf = reg_wdata[1:0]; end
      ms = ns;
    end
  end

  task automatic chk(input string nm, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", last_tag, nm, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("cpu_clk_en", cpu_clk_en, ms == 0);
    chk("per_clk_en", per_clk_en, ms <= 1);
    chk("clk_sel", clk_sel, (ms <= 1) ? ma : 0);
    chk("mode_code", mode_code, (ms == 0) ? ma : (ms == 1) ? 4 + ma : 0);
  endtask

  task automatic cyc(input string t, input logic w, input logic [7:0] d,
                     input logic s, input logic k, input logic [2:0] r);
    @(negedge clk);
    check_all();
    last_tag = t;
    reg_we = w; reg_wdata = d; sleep_cmd = s; wake = k; src_ready = r;
  endtask

  task automatic idle_n(input string t, input int n, input logic [2:0] r);
    for (int i = 0; i < n; i++) cyc(t, 0, 8'h00, 0, 0, r);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle_n("R1", 3, 3'b111);
    // R6 R7 move to secondary while it is not running
    cyc("R7", 1, 8'h01, 0, 0, 3'b101);
    idle_n("R7", 4, 3'b101);
    idle_n("R6", 2, 3'b111);
    // R6 codes 10 and 11 both internal
    cyc("R6", 1, 8'h02, 0, 0, 3'b111);
    idle_n("R6", 2, 3'b111);
    cyc("R6", 1, 8'h03, 0, 0, 3'b111);
    idle_n("R6", 2, 3'b111);
    cyc("R6", 1, 8'h00, 0, 0, 3'b111);
    idle_n("R2", 2, 3'b111);
    // R3 idle then R8 wake; R10 sleep in idle ignored
    cyc("R3", 1, 8'h81, 0, 0, 3'b111);
    idle_n("R3", 2, 3'b111);
    cyc("R3", 0, 8'h00, 1, 0, 3'b111);
    idle_n("R3", 2, 3'b111);
    cyc("R10", 0, 8'h00, 1, 0, 3'b111);
    idle_n("R10", 2, 3'b111);
    // R7 switch while in idle, waits for ready
    cyc("R7", 1, 8'h83, 0, 0, 3'b011);
    idle_n("R7", 3, 3'b011);
    idle_n("R7", 2, 3'b111);
    cyc("R8", 0, 8'h00, 0, 1, 3'b111);
    idle_n("R8", 2, 3'b111);
    // R10 wake in run ignored
    cyc("R10", 0, 8'h00, 0, 1, 3'b111);
    idle_n("R10", 2, 3'b111);
    // R4 sleep, R9 wake with ready
    cyc("R4", 1, 8'h03, 0, 0, 3'b111);
    idle_n("R4", 1, 3'b111);
    cyc("R4", 0, 8'h00, 1, 0, 3'b111);
    idle_n("R4", 3, 3'b111);
    cyc("R9", 0, 8'h00, 0, 1, 3'b111);
    idle_n("R9", 2, 3'b111);
    // R9 wake with pending switch to secondary that is not running
    cyc("R9", 1, 8'h01, 0, 0, 3'b101);
    cyc("R9", 0, 8'h00, 1, 0, 3'b101);
    idle_n("R9", 2, 3'b101);
    cyc("R9", 0, 8'h00, 0, 1, 3'b101);
    idle_n("R9", 4, 3'b101);
    cyc("R9", 0, 8'h00, 0, 0, 3'b111);
    idle_n("R9", 3, 3'b111);
    // R5 idle flag sampled before same-cycle write
    cyc("R5", 1, 8'h80, 0, 0, 3'b111);
    cyc("R5", 1, 8'h00, 1, 0, 3'b111);
    idle_n("R5", 2, 3'b111);
    cyc("R5", 0, 8'h00, 0, 1, 3'b111);
    idle_n("R5", 1, 3'b111);
    cyc("R5", 1, 8'h80, 1, 0, 3'b111);
    idle_n("R5", 2, 3'b111);
    cyc("R5", 0, 8'h00, 0, 1, 3'b111);
    idle_n("R2", 3, 3'b111);
    @(negedge clk);
    check_all();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule